// File: doc/BRIEF.md
# YCbCr 4:2:2 and BT.656 Output Formatter

This block sits at the end of a video output path. It takes full-resolution YCbCr pixels at 10 bits per component, together with data enable, horizontal sync, vertical sync and a field flag. It turns them into one of three output formats: 4:2:2 with separate sync pins, 4:2:2 with timing codes embedded in the luma lane, or a multiplexed 8/10-bit stream at twice the pixel rate that always carries embedded codes. A 2-bit mode input selects the format. A width input selects 20-bit (10 bits per lane) or 16-bit (8 bits per lane) operation. A control input keeps the sync pins driven in the embedded formats.

The output is a 30-bit bus of three 10-bit lanes. Chroma uses bits 29:20 and luma uses bits 19:10. Bits 9:0 are always zero. The block halves the chroma rate by averaging each pixel pair. It also inserts the four-word start and end codes around every active span, and uses a four-pixel look-ahead so that start codes can be placed before the data enable rises. Double rate is modelled as a 2x clock with a pixel on every other cycle.

Pixels enter on a valid/ready handshake. In the 4:2:2 formats `in_ready` stays high and one pixel can be taken every cycle. In the multiplexed format each accepted pixel produces two output words, so `in_ready` is low for the cycle after each accept. The output side has `out_valid` and cannot push back.

Top module: `yc422_formatter`

## Requirements
- R1: A pixel is accepted on a rising clock edge where `in_valid` and `in_ready` are both high. Each accept registers one output word with `out_valid` high. In the multiplexed mode (mode 2), a second word follows in the next cycle, and `in_ready` is low during that cycle. In modes 0, 1 and 3, `in_ready` stays high. The word emitted at an accept belongs to the pixel accepted four accepts earlier; after reset, that pipeline is filled with blanking pixels.
- R2: Chroma is placed on bits 29:20 and luma on bits 19:10, and bits 9:0 are zero. With `wide_lanes` low, each lane carries the upper 8 bits of its 10-bit value and its two low bits are zero.
- R3: In the 4:2:2 modes (0 and 1), every active pixel carries its own luma. On the chroma lane, the first pixel of each pair (counted from the rise of data enable) carries Cb and the second carries Cr.
- R4: The Cb and Cr values of a pair are each the rounded average (a+b+1)>>1 of the pair's two samples.
- R5: In mode 2, the words appear on the luma lane in the order Cb, Y, Cr, Y. Each pixel gives a chroma word and then a luma word, and the chroma lane is zero.
- R6: In the embedded modes, the pixel slots just after data enable falls carry the end code 3FF, 000, 000, XY: four slots in mode 1 (luma lane, chroma lane 0x200) and two slots in mode 2 (two words each). When an end code and a start code would claim the same slot, the end code wins.
- R7: In the embedded modes, the slots just before data enable rises carry the start code in the same four-word form and with the same slot counts.
- R8: XY, from its top bit down, is 1, F, V, H, V^H, F^H, F^V, F^V^H, shifted left by two bits in the 10-bit word. F is the field flag and V the vertical sync of the pixel in the slot. H is 1 in end codes and 0 in start codes.
- R9: Blanking slots that carry no code output 0x200 on chroma and 0x040 on luma (0x80 and 0x10 in 8-bit terms).
- R10: The data enable, horizontal sync, vertical sync and field pins follow the emitted pixel in mode 0, and in modes 1 and 2 when `keep_sync_pins` is high. Otherwise, in modes 1 and 2 they are held at zero.
- R11: If an active span ends on the first pixel of a pair, that pixel's chroma is its own raw Cb, and `odd_span_err` is set. The flag stays set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock (2x pixel rate in mode 2) |
| rst_n | input | 1 | Active-low synchronous reset |
| mode | input | 2 | 0 separate syncs, 1 embedded 4:2:2, 2 multiplexed 656, 3 as 0 |
| wide_lanes | input | 1 | 1: 10-bit lanes, 0: 8-bit lanes in upper bits |
| keep_sync_pins | input | 1 | Drive sync pins in embedded modes |
| in_valid | input | 1 | Input pixel valid |
| in_ready | output | 1 | Block can take a pixel |
| in_de | input | 1 | Data enable of the pixel |
| in_hsync | input | 1 | Horizontal sync of the pixel |
| in_vsync | input | 1 | Vertical sync of the pixel |
| in_field | input | 1 | Field flag of the pixel |
| in_y | input | 10 | Luma |
| in_cb | input | 10 | Blue-difference chroma |
| in_cr | input | 10 | Red-difference chroma |
| out_valid | output | 1 | A new output word is present |
| out_lanes | output | 30 | Lane bus: chroma 29:20, luma 19:10, zero 9:0 |
| out_de | output | 1 | Data enable pin |
| out_hsync | output | 1 | Horizontal sync pin |
| out_vsync | output | 1 | Vertical sync pin |
| out_field | output | 1 | Field pin |
| odd_span_err | output | 1 | Sticky odd-length active span flag |

## Verification
Each accept registers its first output word, so that word and the sync pins can be read one cycle after the accepting edge. In mode 2, the second word and the return of `in_ready` come two cycles after the edge. The word shown always describes the pixel accepted four accepts earlier, so the expected value for accept k is worked out from stream position k-4, including the look-ahead and look-back across that position for codes and chroma pairs. The bench drives each pixel, waits for the accepting edge, and samples at the following falling edge. In mode 2 it samples once more one full cycle later.

// File: rtl/ycfmt_pkg.sv
package ycfmt_pkg;
  localparam int LANE_W   = 10;
  localparam int LANES    = 3;
  localparam int BUS_W    = LANES * LANE_W;
  localparam int CODE_LEN = 4;

  localparam logic [LANE_W-1:0] CHROMA_BLANK = LANE_W'(10'h200);
  localparam logic [LANE_W-1:0] LUMA_BLANK   = LANE_W'(10'h040);
  localparam logic [LANE_W-1:0] NARROW_MASK  = LANE_W'(10'h3FC);

  typedef enum logic [1:0] {
    FMT_SEP = 2'd0,
    FMT_EMB = 2'd1,
    FMT_MUX = 2'd2,
    FMT_ALT = 2'd3
  } fmt_mode_e;

  typedef struct packed {
    logic              de;
    logic              hs;
    logic              vs;
    logic              fld;
    logic [LANE_W-1:0] y;
    logic [LANE_W-1:0] cb;
    logic [LANE_W-1:0] cr;
  } pix_t;

  // word idx 0..3 of a timing code; h=1 marks the end-of-active code
  function automatic logic [LANE_W-1:0] sync_word(input logic [1:0] idx,
                                                  input logic f, input logic v,
                                                  input logic h);
    logic [7:0] xy;
    xy = {1'b1, f, v, h, v ^ h, f ^ h, f ^ v, f ^ v ^ h};
    case (idx)
      2'd0:    sync_word = '1;
      2'd3:    sync_word = {xy, 2'b00};
      default: sync_word = '0;
    endcase
  endfunction

  function automatic logic [LANE_W-1:0] avg2(input logic [LANE_W-1:0] a,
                                             input logic [LANE_W-1:0] b);
    logic [LANE_W:0] s;
    s = {1'b0, a} + {1'b0, b} + (LANE_W+1)'(1);
    return s[LANE_W:1];
  endfunction
endpackage

// File: rtl/ycfmt_lookahead.sv
module ycfmt_lookahead
  import ycfmt_pkg::*;
#(
  parameter int DEPTH = CODE_LEN
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  pix_t             din,
  output pix_t             cur,
  output logic             nxt_de,
  output logic [LANE_W-1:0] nxt_cb,
  output logic [LANE_W-1:0] nxt_cr,
  output logic [DEPTH:1]   ahead_de
);
  pix_t stg [DEPTH];

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_stage
      if (i == 0) begin : g_head
        always_ff @(posedge clk) begin
          if (!rst_n)   stg[0] <= '0;
          else if (adv) stg[0] <= din;
        end
      end else begin : g_body
        always_ff @(posedge clk) begin
          if (!rst_n)   stg[i] <= '0;
          else if (adv) stg[i] <= stg[i-1];
        end
      end
    end
    // distance d ahead of the emitted pixel; DEPTH is the pixel arriving now
    for (genvar d = 1; d <= DEPTH; d++) begin : g_ahead
      if (d == DEPTH) begin : g_in
        assign ahead_de[d] = din.de;
      end else begin : g_st
        assign ahead_de[d] = stg[DEPTH-1-d].de;
      end
    end
  endgenerate

  assign cur    = stg[DEPTH-1];
  assign nxt_de = stg[DEPTH-2].de;
  assign nxt_cb = stg[DEPTH-2].cb;
  assign nxt_cr = stg[DEPTH-2].cr;
endmodule

// File: rtl/ycfmt_sync.sv
module ycfmt_sync #(
  parameter int SPAN = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          adv,
  input  logic          dense,
  input  logic          cur_de,
  input  logic [SPAN:1] ahead_de,
  output logic          code_act,
  output logic          code_eav,
  output logic [1:0]    code_idx
);
  localparam int GW = $clog2(SPAN + 1);

  logic [GW-1:0] gap;
  int            lim;

  assign lim = dense ? SPAN / 2 : SPAN;

  always_comb begin
    code_act = 1'b0;
    code_eav = 1'b0;
    code_idx = 2'd0;
    if (!cur_de) begin
      if (int'(gap) < lim) begin
        code_act = 1'b1;
        code_eav = 1'b1;
        code_idx = gap[1:0];
      end else begin
        for (int d = SPAN; d >= 1; d--) begin
          if (d <= lim && ahead_de[d]) begin
            code_act = 1'b1;
            code_idx = 2'(lim - d);
          end
        end
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)                gap <= GW'(SPAN);
    else if (adv) begin
      if (cur_de)              gap <= '0;
      else if (int'(gap) < SPAN) gap <= gap + GW'(1);
    end
  end
endmodule

// File: rtl/ycfmt_chroma.sv
module ycfmt_chroma
  import ycfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              adv,
  input  logic              cur_de,
  input  logic [LANE_W-1:0] cur_cb,
  input  logic [LANE_W-1:0] cur_cr,
  input  logic              nxt_de,
  input  logic [LANE_W-1:0] nxt_cb,
  input  logic [LANE_W-1:0] nxt_cr,
  output logic [LANE_W-1:0] c_word,
  output logic              lone_err
);
  logic              prev_de;
  logic              odd_next;
  logic [LANE_W-1:0] cr_hold;
  logic              first, odd_now, lead, dangling;

  assign first    = cur_de && !prev_de;
  assign odd_now  = cur_de && !first && odd_next;
  assign lead     = cur_de && !odd_now;
  assign dangling = lead && !nxt_de;

  always_comb begin
    if (!cur_de)      c_word = CHROMA_BLANK;
    else if (odd_now) c_word = cr_hold;
    else if (nxt_de)  c_word = avg2(cur_cb, nxt_cb);
    else              c_word = cur_cb;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prev_de  <= 1'b0;
      odd_next <= 1'b0;
      cr_hold  <= '0;
      lone_err <= 1'b0;
    end else if (adv) begin
      prev_de  <= cur_de;
      odd_next <= lead;
      if (lead && nxt_de) cr_hold <= avg2(cur_cr, nxt_cr);
      if (dangling)       lone_err <= 1'b1;
    end
  end
endmodule

// File: rtl/yc422_formatter.sv
module yc422_formatter
  import ycfmt_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [1:0]        mode,
  input  logic              wide_lanes,
  input  logic              keep_sync_pins,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic              in_de,
  input  logic              in_hsync,
  input  logic              in_vsync,
  input  logic              in_field,
  input  logic [LANE_W-1:0] in_y,
  input  logic [LANE_W-1:0] in_cb,
  input  logic [LANE_W-1:0] in_cr,
  output logic              out_valid,
  output logic [BUS_W-1:0]  out_lanes,
  output logic              out_de,
  output logic              out_hsync,
  output logic              out_vsync,
  output logic              out_field,
  output logic              odd_span_err
);
  fmt_mode_e         md;
  logic              pend, adv;
  pix_t              din, cur;
  logic              nxt_de;
  logic [LANE_W-1:0] nxt_cb, nxt_cr;
  logic [CODE_LEN:1] ahead_de;
  logic              code_act, code_eav;
  logic [1:0]        code_idx;
  logic [LANE_W-1:0] c_word, luma, c_lane, l_lane, w_b, word_b;
  logic              pins_on;

  assign md       = fmt_mode_e'(mode);
  assign in_ready = !pend;
  assign adv      = in_valid && in_ready;
  assign din      = {in_de, in_hsync, in_vsync, in_field, in_y, in_cb, in_cr};

  ycfmt_lookahead #(.DEPTH(CODE_LEN)) look_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .din(din), .cur(cur),
    .nxt_de(nxt_de), .nxt_cb(nxt_cb), .nxt_cr(nxt_cr), .ahead_de(ahead_de)
  );

  ycfmt_sync #(.SPAN(CODE_LEN)) sync_i (
    .clk(clk), .rst_n(rst_n), .adv(adv), .dense(md == FMT_MUX),
    .cur_de(cur.de), .ahead_de(ahead_de),
    .code_act(code_act), .code_eav(code_eav), .code_idx(code_idx)
  );

  ycfmt_chroma chroma_i (
    .clk(clk), .rst_n(rst_n), .adv(adv),
    .cur_de(cur.de), .cur_cb(cur.cb), .cur_cr(cur.cr),
    .nxt_de(nxt_de), .nxt_cb(nxt_cb), .nxt_cr(nxt_cr),
    .c_word(c_word), .lone_err(odd_span_err)
  );

  function automatic logic [LANE_W-1:0] fit(input logic [LANE_W-1:0] v, input logic wide);
    return wide ? v : (v & NARROW_MASK);
  endfunction

  assign luma    = cur.de ? cur.y : LUMA_BLANK;
  assign pins_on = (md == FMT_SEP) || (md == FMT_ALT) || keep_sync_pins;

  always_comb begin
    c_lane = c_word;
    l_lane = luma;
    w_b    = '0;
    case (md)
      FMT_EMB: begin
        if (code_act) begin
          c_lane = CHROMA_BLANK;
          l_lane = sync_word(code_idx, cur.fld, cur.vs, code_eav);
        end
      end
      FMT_MUX: begin
        c_lane = '0;
        l_lane = code_act ? sync_word({code_idx[0], 1'b0}, cur.fld, cur.vs, code_eav) : c_word;
        w_b    = code_act ? sync_word({code_idx[0], 1'b1}, cur.fld, cur.vs, code_eav) : luma;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      out_lanes <= '0;
      out_valid <= 1'b0;
      out_de    <= 1'b0;
      out_hsync <= 1'b0;
      out_vsync <= 1'b0;
      out_field <= 1'b0;
      pend      <= 1'b0;
      word_b    <= '0;
    end else if (adv) begin
      out_lanes <= {fit(c_lane, wide_lanes), fit(l_lane, wide_lanes), {LANE_W{1'b0}}};
      out_valid <= 1'b1;
      out_de    <= pins_on && cur.de;
      out_hsync <= pins_on && cur.hs;
      out_vsync <= pins_on && cur.vs;
      out_field <= pins_on && cur.fld;
      pend      <= (md == FMT_MUX);
      word_b    <= fit(w_b, wide_lanes);
    end else if (pend) begin
      out_lanes <= {{LANE_W{1'b0}}, word_b, {LANE_W{1'b0}}};
      out_valid <= 1'b1;
      pend      <= 1'b0;
    end else begin
      out_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/yc422_formatter_chk.sv
module yc422_formatter_chk
  import ycfmt_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic [1:0]       mode,
  input logic             wide_lanes,
  input logic             keep_sync_pins,
  input logic             in_valid,
  input logic             in_ready,
  input logic             out_valid,
  input logic [BUS_W-1:0] out_lanes,
  input logic             out_de,
  input logic             out_hsync,
  input logic             out_vsync,
  input logic             out_field,
  input logic             odd_span_err
);
  // R1
  mux_throttle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == 2'd2) |=> (!in_ready && out_valid));

  // R1
  dense_ready_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode != 2'd2) |=> in_ready);

  // R1
  accept_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready) |=> out_valid);

  // R2
  spare_lane_chk: assert property (@(posedge clk) disable iff (!rst_n)
    out_lanes[LANE_W-1:0] == '0);

  // R2
  narrow_pad_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && !wide_lanes) |=>
      (out_lanes[LANE_W+1:LANE_W] == 2'b00 && out_lanes[2*LANE_W+1:2*LANE_W] == 2'b00));

  // R5
  mux_chroma_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == 2'd2) |=> out_lanes[BUS_W-1:2*LANE_W] == '0);

  // R10
  pins_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && in_ready && mode == 2'd1 && !keep_sync_pins) |=>
      (!out_de && !out_hsync && !out_vsync && !out_field));

  // R11
  err_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    odd_span_err |=> odd_span_err);
endmodule

bind yc422_formatter yc422_formatter_chk chk_i (
  .clk(clk), .rst_n(rst_n), .mode(mode), .wide_lanes(wide_lanes),
  .keep_sync_pins(keep_sync_pins), .in_valid(in_valid), .in_ready(in_ready),
  .out_valid(out_valid), .out_lanes(out_lanes), .out_de(out_de),
  .out_hsync(out_hsync), .out_vsync(out_vsync), .out_field(out_field),
  .odd_span_err(odd_span_err)
);

// File: tb/yc422_formatter_tb_top.sv
`timescale 1ns/1ps
module yc422_formatter_tb_top;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [1:0]  mode = 2'd0;
  logic        wide_lanes = 1'b1;
  logic        keep_sync_pins = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic        in_de = 1'b0, in_hsync = 1'b0, in_vsync = 1'b0, in_field = 1'b0;
  logic [9:0]  in_y = '0, in_cb = '0, in_cr = '0;
  logic        out_valid;
  logic [29:0] out_lanes;
  logic        out_de, out_hsync, out_vsync, out_field, odd_span_err;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #2 clk = ~clk;

  yc422_formatter dut_i (
    .clk(clk), .rst_n(rst_n), .mode(mode), .wide_lanes(wide_lanes),
    .keep_sync_pins(keep_sync_pins), .in_valid(in_valid), .in_ready(in_ready),
    .in_de(in_de), .in_hsync(in_hsync), .in_vsync(in_vsync), .in_field(in_field),
    .in_y(in_y), .in_cb(in_cb), .in_cr(in_cr), .out_valid(out_valid),
    .out_lanes(out_lanes), .out_de(out_de), .out_hsync(out_hsync),
    .out_vsync(out_vsync), .out_field(out_field), .odd_span_err(odd_span_err)
  );

  // stream storage
  int   slen;
  logic s_de [64];
  logic s_hs [64];
  logic s_vs [64];
  logic s_fl [64];
  int   s_y  [64];
  int   s_cb [64];
  int   s_cr [64];

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit g_de(int j); return (j >= 0 && j < slen) ? s_de[j] : 1'b0; endfunction
  function automatic bit g_hs(int j); return (j >= 0 && j < slen) ? s_hs[j] : 1'b0; endfunction
  function automatic bit g_vs(int j); return (j >= 0 && j < slen) ? s_vs[j] : 1'b0; endfunction
  function automatic bit g_fl(int j); return (j >= 0 && j < slen) ? s_fl[j] : 1'b0; endfunction
  function automatic int g_y (int j); return (j >= 0 && j < slen) ? s_y[j]  : 0; endfunction
  function automatic int g_cb(int j); return (j >= 0 && j < slen) ? s_cb[j] : 0; endfunction
  function automatic int g_cr(int j); return (j >= 0 && j < slen) ? s_cr[j] : 0; endfunction

  // kind 0: two even spans; kind 1: one span of five pixels
  task automatic build(input int kind);
    for (int i = 0; i < 64; i++) begin
      s_de[i] = 1'b0; s_hs[i] = 1'b0; s_vs[i] = 1'b0; s_fl[i] = 1'b0;
      s_y[i]  = (i * 37 + 5) % 1024;
      s_cb[i] = (i * 53 + 3) % 1024;
      s_cr[i] = (i * 71 + 600) % 1024;
    end
    if (kind == 0) begin
      slen = 37;
      for (int i = 8; i < 14; i++) s_de[i] = 1'b1;
      for (int i = 23; i < 27; i++) s_de[i] = 1'b1;
      s_hs[17] = 1'b1; s_hs[18] = 1'b1;
      for (int i = 20; i <= 30; i++) s_vs[i] = 1'b1;
      for (int i = 22; i < slen; i++) s_fl[i] = 1'b1;
    end else begin
      slen = 25;
      for (int i = 8; i < 13; i++) s_de[i] = 1'b1;
    end
  endtask

  function automatic int code_val(int k, bit f, bit v, bit h);
    int xy;
    xy = 128 + f * 64 + v * 32 + h * 16 + (v ^ h) * 8 + (f ^ h) * 4 + (f ^ v) * 2 + (f ^ v ^ h);
    if (k == 0) return 1023;
    if (k == 3) return xy * 4;
    return 0;
  endfunction

  // expected words for emitted stream position j
  task automatic expect_at(input int j, output int wa_c, output int wa_l, output int wb,
                           output int pins, output string req);
    int  lim, idx, c, l, pos;
    bit  code, eav, found, de;
    lim = (mode == 2'd2) ? 2 : 4;
    code = 0; eav = 0; idx = 0; found = 0;
    de = g_de(j);
    if (!de) begin
      for (int m = 1; m <= lim; m++)
        if (!found && g_de(j - m)) begin found = 1; code = 1; eav = 1; idx = m - 1; end
      for (int d = 1; d <= lim; d++)
        if (!found && g_de(j + d)) begin found = 1; code = 1; idx = lim - d; end
    end
    if (!de) c = 512;
    else begin
      pos = 0;
      while (g_de(j - 1 - pos)) pos++;
      if (pos % 2 == 0) c = g_de(j + 1) ? (g_cb(j) + g_cb(j + 1) + 1) / 2 : g_cb(j);
      else              c = (g_cr(j - 1) + g_cr(j) + 1) / 2;
    end
    l = de ? g_y(j) : 64;
    wa_c = c; wa_l = l; wb = 0;
    if (mode == 2'd1 && code) begin
      wa_c = 512;
      wa_l = code_val(idx, g_fl(j), g_vs(j), eav);
    end else if (mode == 2'd2) begin
      wa_c = 0;
      wa_l = code ? code_val(2 * idx, g_fl(j), g_vs(j), eav) : c;
      wb   = code ? code_val(2 * idx + 1, g_fl(j), g_vs(j), eav) : l;
    end
    if (!wide_lanes) begin wa_c = wa_c & ~3; wa_l = wa_l & ~3; wb = wb & ~3; end
    pins = (mode != 2'd1 && mode != 2'd2) || keep_sync_pins ?
           (g_de(j) * 8 + g_hs(j) * 4 + g_vs(j) * 2 + g_fl(j)) : 0;
    if (code) req = eav ? "R6 R8" : "R7 R8";
    else if (!de) req = "R9";
    else req = (mode == 2'd2) ? "R5 R4" : "R3 R4";
    if (!wide_lanes) req = {req, " R2"};
  endtask

  function automatic int pins_now();
    return out_de * 8 + out_hsync * 4 + out_vsync * 2 + out_field;
  endfunction

  task automatic push(input int k);
    int wa_c, wa_l, wb, pins;
    string req;
    longint exp_bus;
    in_valid = 1'b1;
    in_de = s_de[k]; in_hsync = s_hs[k]; in_vsync = s_vs[k]; in_field = s_fl[k];
    in_y = 10'(s_y[k]); in_cb = 10'(s_cb[k]); in_cr = 10'(s_cr[k]);
    @(posedge clk);
    @(negedge clk);
    in_valid = 1'b0;
    expect_at(k - 4, wa_c, wa_l, wb, pins, req);
    exp_bus = (longint'(wa_c) << 20) | (longint'(wa_l) << 10);
    chk(out_valid == 1'b1, "R1 out_valid", out_valid, 1);
    chk(in_ready == (mode != 2'd2), "R1 in_ready", in_ready, mode != 2'd2);
    chk(out_lanes == 30'(exp_bus), req, out_lanes, exp_bus);
    chk(pins_now() == pins, "R10 pins", pins_now(), pins);
    if (mode == 2'd2) begin
      @(posedge clk);
      @(negedge clk);
      exp_bus = longint'(wb) << 10;
      chk(out_valid == 1'b1, "R1 second word valid", out_valid, 1);
      chk(in_ready == 1'b1, "R1 ready back", in_ready, 1);
      chk(out_lanes == 30'(exp_bus), {req, " second"}, out_lanes, exp_bus);
      chk(pins_now() == pins, "R10 pins second", pins_now(), pins);
    end
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    in_valid = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    chk(out_valid == 1'b0, "R1 reset valid", out_valid, 0);
    chk(out_lanes == '0, "R2 reset lanes", out_lanes, 0);
    chk(in_ready == 1'b1, "R1 reset ready", in_ready, 1);
    chk(odd_span_err == 1'b0, "R11 reset flag", odd_span_err, 0);
  endtask

  task automatic run_stream();
    for (int k = 0; k < slen; k++) push(k);
  endtask

  initial begin
    for (int m = 0; m < 3; m++) begin
      for (int w = 0; w < 2; w++) begin
        for (int kp = 0; kp < 2; kp++) begin
          @(negedge clk);
          mode = 2'(m); wide_lanes = w[0]; keep_sync_pins = kp[0];
          do_reset();
          build(0);
          run_stream();
          chk(odd_span_err == 1'b0, "R11 even spans leave flag low", odd_span_err, 0);
        end
      end
    end
    // R11: odd-length span, dangling chroma raw and sticky flag
    @(negedge clk);
    mode = 2'd0; wide_lanes = 1'b1; keep_sync_pins = 1'b0;
    do_reset();
    build(1);
    run_stream();
    chk(odd_span_err == 1'b1, "R11 odd span flag", odd_span_err, 1);
    repeat (5) @(negedge clk);
    chk(odd_span_err == 1'b1, "R11 flag sticky", odd_span_err, 1);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule